// File: doc/BRIEF.md
# Destination-Tag Butterfly Switching Network

This block is a multistage indirect network with 2^STAGES terminals, assembled from two-input, two-output switch elements arranged in STAGES columns. Every packet carries the index of the terminal it must reach, and each column reads one bit of that index to pick its output port. There are no routing tables and no alternative paths. A given source and destination are joined by exactly one chain of switches, and every packet crosses every column no matter how near its target is.

Terminals present packets on the injection side with a valid/ready handshake and collect them on the ejection side the same way. Each switch output owns a one-entry register, so an unblocked packet moves forward one column per clock. Two inputs that want the same output in the same cycle are served by a two-way round-robin arbiter. The losing input sees its ready held low until it is granted.

Top module: `bfly_net`

## Requirements
- R1: While reset is asserted and directly after it, every `ej_valid` bit is 0. `inj_ready` is 0 for every source whose `inj_valid` is 0.
- R2: A packet injected at any source with destination d leaves at ejection port d with its payload unchanged.
- R3: With no contention and the ejection side ready, a packet accepted on clock edge A shows `ej_valid` high after edge A+STAGES-1 and not after edge A+STAGES-2.
- R4: Column s (s = 0 first, next to the injection side) pairs the lanes that differ only in bit STAGES-1-s. It sends a packet to the lane whose bit STAGES-1-s equals bit STAGES-1-s of the destination: port 0 for a 0, port 1 for a 1.
- R5: When both inputs of a switch request the same output in one cycle, exactly one of them is accepted. For the first contention after reset, the input on the lane whose paired bit is 0 wins.
- R6: At each switch output, a contention is won by the input that was not the most recent one granted at that output.
- R7: A packet that cannot leave keeps `ej_valid` high and its payload stable. A blocked path holds exactly STAGES packets before `inj_ready` drops. When the ejection port becomes ready again, the held packets leave on consecutive cycles in injection order.
- R8: Under random injection and random ejection back-pressure, every packet is delivered exactly once, at its own destination terminal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inj_valid | input | N | Per-source packet present |
| inj_dest | input | N*STAGES | Per-source destination index, source t in bits [t*STAGES +: STAGES] |
| inj_payload | input | N*DATA_W | Per-source payload, source t in bits [t*DATA_W +: DATA_W] |
| inj_ready | output | N | Per-source packet accepted on this edge when valid |
| ej_valid | output | N | Per-terminal packet present |
| ej_payload | output | N*DATA_W | Per-terminal payload, terminal t in bits [t*DATA_W +: DATA_W] |
| ej_ready | input | N | Per-terminal consumer accepts the packet |

## Verification
An unblocked packet spends one register per column. Counting the accepting edge as the first, it is therefore visible at its ejection port after STAGES rising edges. The bench drives inputs one time unit after a rising edge and reads handshakes and outputs at the following falling edge. For every source-destination pair it checks the falling edge before the due one for absence and the due one for presence. The contention and back-pressure sequences are traced edge by edge: grants are checked in the cycle the requests are presented, and deliveries at the falling edges two, three and four edges after the first acceptance.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  // Address bit consumed by column `stage` (most significant first).
  function automatic int stage_bit(input int stage, input int stages);
    return stages - 1 - stage;
  endfunction

  // Lower lane of switch `sw` in a column pairing lanes that differ in `bitpos`:
  // insert a zero at position bitpos into the switch number.
  function automatic int lane_lo(input int sw, input int bitpos);
    return ((sw >> bitpos) << (bitpos + 1)) | (sw & ((1 << bitpos) - 1));
  endfunction

  function automatic int lane_hi(input int sw, input int bitpos);
    return lane_lo(sw, bitpos) | (1 << bitpos);
  endfunction

endpackage

// File: rtl/bfly_rr_arb.sv
module bfly_rr_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic       take,
  output logic [1:0] gnt
);

  logic fav;  // input favoured on a tie

  always_comb begin
    if (req == 2'b11) gnt = fav ? 2'b10 : 2'b01;
    else              gnt = req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    fav <= 1'b0;
    else if (take) fav <= gnt[0];
  end

  assert_gnt_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == 2'b00));

  assert_alternate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req == 2'b11 && take) |=> (req != 2'b11 || gnt != $past(gnt)));

endmodule

// File: rtl/bfly_switch.sv
module bfly_switch #(
  parameter int DATA_W = 8,
  parameter int DEST_W = 3,
  parameter int SEL    = 0,
  localparam int PKT_W = DEST_W + DATA_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            in_valid,
  input  logic [1:0][PKT_W-1:0] in_pkt,
  output logic [1:0]            in_ready,
  output logic [1:0]            out_valid,
  output logic [1:0][PKT_W-1:0] out_pkt,
  input  logic [1:0]            out_ready
);

  logic [1:0]            want_port;
  logic [1:0][1:0]       req;
  logic [1:0][1:0]       gnt;
  logic [1:0]            room;
  logic [1:0]            take;
  logic [1:0]            occ;
  logic [1:0][PKT_W-1:0] hold;

  always_comb begin
    for (int i = 0; i < 2; i++) want_port[i] = in_pkt[i][DATA_W + SEL];
  end

  always_comb begin
    for (int i = 0; i < 2; i++) in_ready[i] = gnt[want_port[i]][i] && room[want_port[i]];
  end

  for (genvar o = 0; o < 2; o++) begin : g_out
    always_comb begin
      for (int i = 0; i < 2; i++) req[o][i] = in_valid[i] && (want_port[i] == 1'(o));
    end

    bfly_rr_arb u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (req[o]),
      .take (take[o]),
      .gnt  (gnt[o])
    );

    assign room[o] = !occ[o] || out_ready[o];
    assign take[o] = (|gnt[o]) && room[o];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        occ[o]  <= 1'b0;
        hold[o] <= '0;
      end else if (take[o]) begin
        occ[o]  <= 1'b1;
        hold[o] <= gnt[o][1] ? in_pkt[1] : in_pkt[0];
      end else if (out_ready[o]) begin
        occ[o]  <= 1'b0;
      end
    end

    assign out_valid[o] = occ[o];
    assign out_pkt[o]   = hold[o];

    assert_route_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] |-> (out_pkt[o][DATA_W + SEL] == 1'(o)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !out_ready[o]) |=> (out_valid[o] && $stable(out_pkt[o])));
  end

  assert_single_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid == 2'b11 && want_port[0] == want_port[1]) |-> (in_ready != 2'b11));

endmodule

// File: rtl/bfly_net.sv
module bfly_net #(
  parameter int  STAGES = 3,
  parameter int  DATA_W = 8,
  localparam int N      = 1 << STAGES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        inj_valid,
  input  logic [N*STAGES-1:0] inj_dest,
  input  logic [N*DATA_W-1:0] inj_payload,
  output logic [N-1:0]        inj_ready,
  output logic [N-1:0]        ej_valid,
  output logic [N*DATA_W-1:0] ej_payload,
  input  logic [N-1:0]        ej_ready
);

  localparam int PKT_W = STAGES + DATA_W;
  localparam int NSW   = N / 2;

  logic [N-1:0]            lv [STAGES+1];
  logic [N-1:0][PKT_W-1:0] lp [STAGES+1];
  logic [N-1:0]            lr [STAGES+1];

  for (genvar t = 0; t < N; t++) begin : g_term
    assign lv[0][t]   = inj_valid[t];
    assign lp[0][t]   = {inj_dest[t*STAGES +: STAGES], inj_payload[t*DATA_W +: DATA_W]};
    assign inj_ready[t] = lr[0][t];

    assign ej_valid[t]                  = lv[STAGES][t];
    assign ej_payload[t*DATA_W +: DATA_W] = lp[STAGES][t][DATA_W-1:0];
    assign lr[STAGES][t]                = ej_ready[t];

    assert_deliver_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ej_valid[t] |-> (lp[STAGES][t][PKT_W-1:DATA_W] == STAGES'(t)));
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_col
    localparam int B = bfly_pkg::stage_bit(s, STAGES);
    for (genvar w = 0; w < NSW; w++) begin : g_sw
      localparam int LO = bfly_pkg::lane_lo(w, B);
      localparam int HI = bfly_pkg::lane_hi(w, B);

      logic [1:0]            sw_iv, sw_ir, sw_ov, sw_or;
      logic [1:0][PKT_W-1:0] sw_ip, sw_op;

      assign sw_iv    = {lv[s][HI], lv[s][LO]};
      assign sw_ip[0] = lp[s][LO];
      assign sw_ip[1] = lp[s][HI];
      assign lr[s][LO] = sw_ir[0];
      assign lr[s][HI] = sw_ir[1];

      assign lv[s+1][LO] = sw_ov[0];
      assign lv[s+1][HI] = sw_ov[1];
      assign lp[s+1][LO] = sw_op[0];
      assign lp[s+1][HI] = sw_op[1];
      assign sw_or       = {lr[s+1][HI], lr[s+1][LO]};

      bfly_switch #(
        .DATA_W(DATA_W),
        .DEST_W(STAGES),
        .SEL   (B)
      ) u_sw (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (sw_iv),
        .in_pkt   (sw_ip),
        .in_ready (sw_ir),
        .out_valid(sw_ov),
        .out_pkt  (sw_op),
        .out_ready(sw_or)
      );
    end
  end

endmodule

// File: tb/bfly_net_test.sv
module bfly_net_test;
  localparam int CLK_PERIOD = 10;
  localparam int ST  = 3;
  localparam int DW  = 8;
  localparam int NT  = 1 << ST;
  localparam int NPK = 200;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NT-1:0]     inj_valid = '0;
  logic [NT*ST-1:0]  inj_dest = '0;
  logic [NT*DW-1:0]  inj_payload = '0;
  logic [NT-1:0]     inj_ready;
  logic [NT-1:0]     ej_valid;
  logic [NT*DW-1:0]  ej_payload;
  logic [NT-1:0]     ej_ready = '1;

  int n_checks = 0;
  int n_fail   = 0;

  logic [ST-1:0] dest_of [NPK];
  bit            seen    [NPK];
  bit            active  [NT];
  int            next_id [NT];
  int            delivered = 0;

  bfly_net #(.STAGES(ST), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .inj_valid(inj_valid), .inj_dest(inj_dest), .inj_payload(inj_payload),
    .inj_ready(inj_ready),
    .ej_valid(ej_valid), .ej_payload(ej_payload), .ej_ready(ej_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input int src, input int dst, input int pay);
    inj_dest[src*ST +: ST]    = ST'(dst);
    inj_payload[src*DW +: DW] = DW'(pay);
    inj_valid[src]            = 1'b1;
  endtask

  function automatic int pay_at(input int t);
    return int'(ej_payload[t*DW +: DW]);
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL R8 watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ej_valid == '0, "R1 ej_valid in reset", int'(ej_valid), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(ej_valid == '0, "R1 ej_valid after reset", int'(ej_valid), 0);
    check(inj_ready == '0, "R1 inj_ready idle", int'(inj_ready), 0);

    // R2 R3 R4: every source to every destination, one packet at a time
    for (int s = 0; s < NT; s++) begin
      for (int d = 0; d < NT; d++) begin
        int p;
        p = ((s * 16 + d) ^ 8'h5A) & 8'hFF;
        @(posedge clk); #1 put(s, d, p);
        @(negedge clk);
        check(inj_ready[s] == 1'b1, "R3 lone accept", int'(inj_ready[s]), 1);
        @(posedge clk); #1 inj_valid[s] = 1'b0;   // accepting edge A
        repeat (ST - 2) @(posedge clk);
        @(negedge clk);
        check(ej_valid == '0, "R3 not early", int'(ej_valid), 0);
        @(posedge clk);
        @(negedge clk);
        check(ej_valid == NT'(1 << d), "R2 R4 terminal", int'(ej_valid), 1 << d);
        check(pay_at(d) == p, "R2 payload", pay_at(d), p);
      end
    end
    repeat (4) @(posedge clk);

    // R5 R6: sources 0 and 4 share a first-column switch, both to terminal 0
    #1 put(0, 0, 8'hA1); put(4, 0, 8'hB1);
    @(negedge clk);
    check(inj_ready[0] == 1'b1, "R5 low lane wins", int'(inj_ready[0]), 1);
    check(inj_ready[4] == 1'b0, "R5 loser held", int'(inj_ready[4]), 0);
    @(posedge clk); #1 put(0, 0, 8'hA2);
    @(negedge clk);
    check(inj_ready[4] == 1'b1, "R6 other input wins", int'(inj_ready[4]), 1);
    check(inj_ready[0] == 1'b0, "R6 last winner held", int'(inj_ready[0]), 0);
    @(posedge clk); #1 inj_valid[4] = 1'b0;
    @(negedge clk);
    check(inj_ready[0] == 1'b1, "R6 alone accepted", int'(inj_ready[0]), 1);
    @(posedge clk); #1 inj_valid[0] = 1'b0;
    @(negedge clk);
    check(ej_valid[0] && pay_at(0) == 8'hA1, "R5 first out", pay_at(0), 8'hA1);
    @(negedge clk);
    check(ej_valid[0] && pay_at(0) == 8'hB1, "R6 second out", pay_at(0), 8'hB1);
    @(negedge clk);
    check(ej_valid[0] && pay_at(0) == 8'hA2, "R6 third out", pay_at(0), 8'hA2);
    @(negedge clk);
    check(ej_valid == '0, "R5 drained", int'(ej_valid), 0);
    repeat (3) @(posedge clk);

    // R7: blocked ejection port 0, source 0 streams to terminal 0
    #1 ej_ready[0] = 1'b0; put(0, 0, 8'hC1);
    @(negedge clk);
    check(inj_ready[0] == 1'b1, "R7 fill 1", int'(inj_ready[0]), 1);
    @(posedge clk); #1 put(0, 0, 8'hC2);
    @(negedge clk);
    check(inj_ready[0] == 1'b1, "R7 fill 2", int'(inj_ready[0]), 1);
    @(posedge clk); #1 put(0, 0, 8'hC3);
    @(negedge clk);
    check(inj_ready[0] == 1'b1, "R7 fill 3", int'(inj_ready[0]), 1);
    @(posedge clk); #1 put(0, 0, 8'hC4);
    @(negedge clk);
    check(inj_ready[0] == 1'b0, "R7 full", int'(inj_ready[0]), 0);
    check(ej_valid[0] && pay_at(0) == 8'hC1, "R7 head shown", pay_at(0), 8'hC1);
    @(negedge clk);
    check(inj_ready[0] == 1'b0, "R7 still full", int'(inj_ready[0]), 0);
    check(ej_valid[0] && pay_at(0) == 8'hC1, "R7 head stable", pay_at(0), 8'hC1);
    @(posedge clk); #1 ej_ready[0] = 1'b1;
    @(negedge clk);
    check(inj_ready[0] == 1'b1, "R7 resume", int'(inj_ready[0]), 1);
    check(ej_valid[0] && pay_at(0) == 8'hC1, "R7 out 1", pay_at(0), 8'hC1);
    @(posedge clk); #1 inj_valid[0] = 1'b0;
    @(negedge clk);
    check(ej_valid[0] && pay_at(0) == 8'hC2, "R7 out 2", pay_at(0), 8'hC2);
    @(negedge clk);
    check(ej_valid[0] && pay_at(0) == 8'hC3, "R7 out 3", pay_at(0), 8'hC3);
    @(negedge clk);
    check(ej_valid[0] && pay_at(0) == 8'hC4, "R7 out 4", pay_at(0), 8'hC4);
    @(negedge clk);
    check(ej_valid == '0, "R7 drained", int'(ej_valid), 0);

    // R8: random traffic, payload carries a unique packet number
    for (int i = 0; i < NPK; i++) begin
      dest_of[i] = ST'($urandom % NT);
      seen[i]    = 1'b0;
    end
    for (int s = 0; s < NT; s++) begin
      active[s]  = 1'b0;
      next_id[s] = s;
    end
    for (int cyc = 0; cyc < 5000 && delivered < NPK; cyc++) begin
      @(posedge clk); #1;
      for (int s = 0; s < NT; s++) begin
        if (!active[s] && next_id[s] < NPK && ($urandom % 2) == 0) begin
          put(s, int'(dest_of[next_id[s]]), next_id[s]);
          next_id[s] += NT;
          active[s] = 1'b1;
        end
        inj_valid[s] = active[s];
      end
      ej_ready = NT'($urandom) | NT'($urandom);
      @(negedge clk);
      for (int t = 0; t < NT; t++) begin
        if (ej_valid[t] && ej_ready[t]) begin
          int id;
          id = pay_at(t);
          if (id < NPK) begin
            check(int'(dest_of[id]) == t, "R8 terminal", t, int'(dest_of[id]));
            check(!seen[id], "R8 duplicate", int'(seen[id]), 0);
            seen[id] = 1'b1;
          end else begin
            check(1'b0, "R8 unknown packet", id, 0);
          end
          delivered++;
        end
      end
      for (int s = 0; s < NT; s++) begin
        if (inj_valid[s] && inj_ready[s]) active[s] = 1'b0;
      end
    end
    @(posedge clk); #1 inj_valid = '0; ej_ready = '1;
    check(delivered == NPK, "R8 all delivered", delivered, NPK);

    summary();
    $finish;
  end

endmodule